// File: doc/BRIEF.md
# Latched Overvoltage Guard for a Multiphase Regulator

This block watches the sensed output voltage of a multiphase buck regulator, given in millivolts, and decides how the PWM outputs of all phases behave. While no fault has been seen, every phase runs in normal mode. When the sensed voltage rises above the trip level, all phases are forced low on the next clock edge so that the low-side switches pull the output down. Once the voltage drops below a release level set just above the DAC target, the phases move to high-impedance. If the voltage climbs over the trip level again, the phases go back to forced low. This clamp and release cycling repeats for as long as the overvoltage keeps coming back.

The trip level depends on the regulator's state. While the regulator is disabled, in soft-start, or has no valid VID yet, a fixed level is used. Once it is enabled with a valid VID and out of soft-start, the trip level is the DAC target plus an offset. Monitoring runs from the moment power-on-reset is released, even while the regulator is disabled. After any trip, a fault flag is latched and normal mode cannot return until power-on-reset or a falling edge of the enable input. A change of VID or DAC code does not clear the flag.

Top module: `ovp_guard`

## Requirements
- R1: After power-on-reset (`rst` high at a clock edge), every phase mode is normal (2'b00) and `ovp_latched` is 0.
- R2: While `en` is 0, `soft_start` is 1 or `vid_ok` is 0, a trip happens when `vsense_mv` > 1273. A value of exactly 1273 does not trip.
- R3: While `en` is 1, `vid_ok` is 1 and `soft_start` is 0, a trip happens when `vsense_mv` > `dac_mv` + 175. A value of exactly `dac_mv` + 175 does not trip.
- R4: A trip sampled at a clock edge makes every phase forced low (2'b01) and sets `ovp_latched` to 1, both visible right after that same edge.
- R5: While the phases are forced low and no trip is present, `vsense_mv` < `dac_mv` + 75 moves every phase to high-impedance (2'b10) at the next edge. At exactly `dac_mv` + 75 the phases stay forced low.
- R6: From high-impedance, a new trip returns the phases to forced low. Between the release and trip levels the phases keep their current mode.
- R7: Once `ovp_latched` is 1, it stays 1 and the phases never show normal mode, whatever `vid_ok`, `dac_mv` or `soft_start` do, until R8 applies.
- R8: A 1-to-0 transition of `en` seen between two edges, or `rst`, clears `ovp_latched` and returns the phases to normal at that edge. The clear takes priority over a trip in the same cycle.
- R9: Overvoltage monitoring runs while `en` is 0: a trip in that state latches the fault just as it does when enabled.
- R10: All NPH phase fields of `pwm_mode` always carry the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on-reset |
| en | input | 1 | Regulator enable; a falling edge clears the fault |
| vid_ok | input | 1 | A valid VID code has been detected |
| soft_start | input | 1 | Regulator is in a soft-start interval |
| vsense_mv | input | W | Sensed differential output voltage, mV |
| dac_mv | input | W | DAC target voltage, mV |
| pwm_mode | output | 2*NPH | Per-phase mode, phase i in bits [2i+1:2i]: 00 normal, 01 forced low, 10 high-impedance |
| ovp_latched | output | 1 | Latched overvoltage fault |

## Verification
Directed patterns place `vsense_mv` at and one millivolt past the fixed trip level, the DAC-relative trip level and the release level. These cases show which threshold is selected in each regulator state and whether the comparisons are strict. Other directed sequences change the VID and DAC codes while a fault is latched, lower the enable, and trip while disabled. They separate the conditions that clear the latch from those that must not. Random stimulus keeps the voltage in a band around the DAC target and the fixed level, with occasional enable, VID and soft-start changes. This drives many clamp, release and re-clamp cycles, and a bench model checks each cycle.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    PWM_NORM = 2'b00,
    PWM_LOW  = 2'b01,
    PWM_HIZ  = 2'b10
  } pwm_mode_e;
endpackage

// File: rtl/ovp_thresh.sv
module ovp_thresh #(
  parameter int W        = 12,
  parameter int FIXED_MV = 1273,
  parameter int TRIP_OFS = 175,
  parameter int REL_OFS  = 75
) (
  input  logic         en,
  input  logic         vid_ok,
  input  logic         soft_start,
  input  logic [W-1:0] vsense_mv,
  input  logic [W-1:0] dac_mv,
  output logic         trip,
  output logic         below_rel
);
  localparam int XW = W + 1;
  localparam logic [XW-1:0] FIX_X  = XW'(FIXED_MV);
  localparam logic [XW-1:0] TRIP_X = XW'(TRIP_OFS);
  localparam logic [XW-1:0] REL_X  = XW'(REL_OFS);

  logic [XW-1:0] vs_x, dac_x, trip_lvl, rel_lvl;
  logic          use_dac;

  always_comb begin
    vs_x     = {1'b0, vsense_mv};
    dac_x    = {1'b0, dac_mv};
    use_dac  = en && vid_ok && !soft_start;
    trip_lvl = use_dac ? (dac_x + TRIP_X) : FIX_X;
    rel_lvl  = dac_x + REL_X;
    trip      = vs_x > trip_lvl;
    below_rel = vs_x < rel_lvl;
  end
endmodule

// File: rtl/ovp_latch.sv
module ovp_latch
  import ovp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      trip,
  input  logic      below_rel,
  output pwm_mode_e mode_d,
  output logic      latched
);
  logic en_q, clamp_q, lat_q;
  logic clamp_d, lat_d, clr;

  always_comb begin
    clr     = en_q && !en;
    clamp_d = clamp_q;
    lat_d   = lat_q;
    if (clr) begin
      clamp_d = 1'b0;
      lat_d   = 1'b0;
    end else if (trip) begin
      clamp_d = 1'b1;
      lat_d   = 1'b1;
    end else if (clamp_q && below_rel) begin
      clamp_d = 1'b0;
    end
    if (clamp_d)    mode_d = PWM_LOW;
    else if (lat_d) mode_d = PWM_HIZ;
    else            mode_d = PWM_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      clamp_q <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      en_q    <= en;
      clamp_q <= clamp_d;
      lat_q   <= lat_d;
    end
  end

  assign latched = lat_q;

  // R4
  trip_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (trip && !(en_q && !en)) |=> (clamp_q && lat_q));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_q && !trip && below_rel && !(en_q && !en)) |=> (!clamp_q && lat_q));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_q && !(en_q && !en)) |=> lat_q);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !en) |=> (!lat_q && !clamp_q));
endmodule

// File: rtl/ovp_phase_drv.sv
module ovp_phase_drv
  import ovp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwm_mode_e  mode_d,
  output logic [1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= PWM_NORM;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/ovp_guard.sv
module ovp_guard
  import ovp_pkg::*;
#(
  parameter int W        = 12,
  parameter int NPH      = 4,
  parameter int FIXED_MV = 1273,
  parameter int TRIP_OFS = 175,
  parameter int REL_OFS  = 75
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             vid_ok,
  input  logic             soft_start,
  input  logic [W-1:0]     vsense_mv,
  input  logic [W-1:0]     dac_mv,
  output logic [2*NPH-1:0] pwm_mode,
  output logic             ovp_latched
);
  logic      trip, below_rel;
  pwm_mode_e mode_d;

  ovp_thresh #(
    .W(W), .FIXED_MV(FIXED_MV), .TRIP_OFS(TRIP_OFS), .REL_OFS(REL_OFS)
  ) u_thresh (
    .en(en), .vid_ok(vid_ok), .soft_start(soft_start),
    .vsense_mv(vsense_mv), .dac_mv(dac_mv),
    .trip(trip), .below_rel(below_rel)
  );

  ovp_latch u_latch (
    .clk(clk), .rst(rst), .en(en), .trip(trip), .below_rel(below_rel),
    .mode_d(mode_d), .latched(ovp_latched)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ovp_phase_drv u_drv (
      .clk(clk), .rst(rst), .mode_d(mode_d),
      .mode_q(pwm_mode[2*p +: 2])
    );
  end

  // R7
  no_norm_when_latched_chk: assert property (@(posedge clk) disable iff (rst)
    ovp_latched |-> (pwm_mode[1:0] != PWM_NORM));
  // R10
  phase_match_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_mode == {NPH{pwm_mode[1:0]}});
endmodule

// File: tb/tb_ovp_guard.sv
`timescale 1ns/1ps
module tb_ovp_guard;
  localparam int W = 12;
  localparam int NPH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, vid_ok = 1'b0, soft_start = 1'b0;
  logic [W-1:0] vsense_mv = '0, dac_mv = '0;
  logic [2*NPH-1:0] pwm_mode;
  logic ovp_latched;

  int total = 0, bad = 0;
  bit m_en = 0, m_clamp = 0, m_lat = 0;

  always #10 clk = ~clk;

  ovp_guard #(.W(W), .NPH(NPH)) dut (
    .clk(clk), .rst(rst), .en(en), .vid_ok(vid_ok), .soft_start(soft_start),
    .vsense_mv(vsense_mv), .dac_mv(dac_mv),
    .pwm_mode(pwm_mode), .ovp_latched(ovp_latched)
  );

  function automatic logic [1:0] exp_mode();
    return m_clamp ? 2'b01 : (m_lat ? 2'b10 : 2'b00);
  endfunction

  task automatic model_upd();
    int thr;
    bit trip, rel;
    if (rst) begin
      m_en = 0; m_clamp = 0; m_lat = 0;
    end else begin
      thr  = (en && vid_ok && !soft_start) ? int'(dac_mv) + 175 : 1273;
      trip = int'(vsense_mv) > thr;
      rel  = int'(vsense_mv) < int'(dac_mv) + 75;
      if (m_en && !en) begin m_clamp = 0; m_lat = 0; end
      else if (trip) begin m_clamp = 1; m_lat = 1; end
      else if (m_clamp && rel) m_clamp = 0;
      m_en = en;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_upd();
    #1;
  endtask

  task automatic expect_st(string tag, logic [1:0] m, logic l);
    total++;
    if (pwm_mode !== {NPH{m}} || ovp_latched !== l) begin
      bad++;
      $display("FAIL %s: mode=%h lat=%b expected mode=%h lat=%b",
               tag, pwm_mode, ovp_latched, {NPH{m}}, l);
    end
  endtask

  task automatic drive(logic r, logic e, logic v, logic s, int vs, int d);
    rst = r; en = e; vid_ok = v; soft_start = s;
    vsense_mv = W'(vs); dac_mv = W'(d);
    cyc();
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    drive(1, 0, 0, 0, 0, 1100);
    drive(1, 0, 0, 0, 0, 1100);
    expect_st("R1 reset", 2'b00, 1'b0);
    drive(0, 0, 0, 0, 1273, 1100);
    expect_st("R2 at fixed level no trip", 2'b00, 1'b0);
    drive(0, 1, 1, 1, 1273, 1000);
    expect_st("R2 soft-start at fixed level", 2'b00, 1'b0);
    drive(0, 1, 1, 1, 1274, 1000);
    expect_st("R2 R4 soft-start trip above fixed", 2'b01, 1'b1);
    drive(1, 0, 0, 0, 0, 1100);
    expect_st("R8 rst clears", 2'b00, 1'b0);
    drive(0, 1, 1, 0, 1275, 1100);
    expect_st("R3 at dac+175 no trip", 2'b00, 1'b0);
    drive(0, 1, 1, 0, 1276, 1100);
    expect_st("R3 R4 trip above dac+175", 2'b01, 1'b1);
    drive(0, 1, 1, 0, 1175, 1100);
    expect_st("R5 at release level stays low", 2'b01, 1'b1);
    drive(0, 1, 1, 0, 1174, 1100);
    expect_st("R5 below release goes hiz", 2'b10, 1'b1);
    drive(0, 1, 1, 0, 1200, 1100);
    expect_st("R6 between levels stays hiz", 2'b10, 1'b1);
    drive(0, 1, 1, 0, 1276, 1100);
    expect_st("R6 retrip forced low", 2'b01, 1'b1);
    drive(0, 1, 0, 0, 900, 1300);
    drive(0, 1, 1, 0, 900, 1200);
    drive(0, 1, 1, 1, 900, 1000);
    expect_st("R7 vid/dac change keeps latch", 2'b10, 1'b1);
    drive(0, 0, 1, 0, 900, 1000);
    expect_st("R8 enable fall clears", 2'b00, 1'b0);
    drive(0, 1, 1, 0, 1000, 1000);
    drive(0, 0, 1, 0, 1400, 1000);
    expect_st("R8 clear beats trip", 2'b00, 1'b0);
    drive(0, 0, 1, 0, 1400, 1000);
    expect_st("R9 trip while disabled", 2'b01, 1'b1);
    drive(0, 0, 1, 0, 1000, 1000);
    expect_st("R9 release while disabled", 2'b10, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      int d, vs;
      d = 900 + int'($urandom % 500);
      if ($urandom % 3 == 0) vs = 1200 + int'($urandom % 150);
      else vs = d - 110 + int'($urandom % 360);
      drive(($urandom % 400) == 0, ($urandom % 40) != 0,
            ($urandom % 10) != 0, ($urandom % 12) == 0, vs, d);
      expect_st("R6 random cycle", exp_mode(), m_lat);
      total++;
      if (pwm_mode !== {NPH{pwm_mode[1:0]}}) begin
        bad++;
        $display("FAIL R10 phases differ: mode=%h expected all=%h",
                 pwm_mode, pwm_mode[1:0]);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule